// File: doc/BRIEF.md
# Per-Byte CRC Status Register

This block sits beside a two-wire serial interface controller and keeps a running CRC-8 over every data byte that controller finishes, in either direction. Each time the controller reports a completed byte, the block folds that byte into the running value. It then exposes the result in a read-only register and marks it ready with a buffer-full flag. Software reads the register to obtain the check byte for the most recent data byte. A clear strobe at the start of a message restarts the running value.

The ready flag manages itself. A CPU read of the register drops it. If software never reads it, hardware drops it for at least one cycle before the next result is written, so every load shows up as a fresh rising edge of the flag. Driving the module enable low returns all state to its reset values.

The polynomial, width, initial value and bit order are parameters. The default is x^8+x^2+x+1 with a zero seed, shifted most significant bit first.

Top module: `crc_byte_status`

## Requirements
- R1: With the defaults, each byte strobe taken while enabled advances the running CRC by that byte, using polynomial 0x07, seed 0x00 and MSB-first order. The nine bytes 0x31 to 0x39 in that order, after a clear, give 0xF4.
- R2: A byte strobe sampled at clock edge k loads the updated CRC into `crc_o` at edge k+1. When no further strobe is sampled at edge k+1, `full_o` is also set at that edge.
- R3: When `rd_i` is high while `full_o` is 1 and no load falls on that edge, `full_o` is 0 after the edge and `crc_o` keeps its value.
- R4: Every sampled byte strobe forces `full_o` to 0 after that edge, so the flag is low for at least one cycle before each load. During an unbroken run of strobes the flag stays low, and it rises only at the edge after the last strobe.
- R5: After reset, `crc_o` is 0x00 and `full_o` is 0.
- R6: A clear strobe sets the running value back to the seed before any byte sampled in the same cycle is folded in. The clear alone changes neither `crc_o` nor `full_o`.
- R7: When a read and a load fall on the same edge, the load wins and `full_o` is 1 afterwards.
- R8: While `en_i` is 0, the running CRC, `crc_o` and `full_o` are at their reset values after each edge, and byte strobes have no effect.
- R9: While `full_o` stays 1 from one cycle to the next, `crc_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| byte_done_i | input | 1 | One-cycle strobe: a data byte has completed |
| byte_i | input | DATA_W | Value of the completed byte, valid with the strobe |
| crc_clr_i | input | 1 | Restart the running CRC from the seed |
| rd_i | input | 1 | CPU read of the CRC register |
| crc_o | output | CRC_W | CRC register contents |
| full_o | output | 1 | CRC register holds an unread result |

## Verification
Every result in this block is due at a fixed distance from its cause. A strobe pulls the flag low after the edge that samples it. The register and the raised flag follow one edge later. A read or a disable takes effect after the single edge that samples it. The bench drives inputs and checks outputs on the falling clock edge. Its behavioural model advances on the rising edge with the same register count, so the comparison made after each rising edge lines up with the cycle in which that result is due. The directed checks for the string check value, collisions, clears and disable wait exactly the one or two edges listed in the requirements before they sample.

// File: rtl/crc_status_pkg.sv
package crc_status_pkg;

   // Largest CRC width the reflection helper supports
   localparam int unsigned CRC_W_MAX = 32;

   // Mirror the low w bits of v, for the LSB-first variant
   function automatic logic [CRC_W_MAX-1:0] mirror_bits(
      input logic [CRC_W_MAX-1:0] v,
      input int unsigned          w
   );
      logic [CRC_W_MAX-1:0] r;
      r = '0;
      for (int unsigned i = 0; i < CRC_W_MAX; i++) begin
         if (i < w) r[i] = v[w-1-i];
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_step.sv
module crc_step #(
   parameter int unsigned      DATA_W    = 8,
   parameter int unsigned      CRC_W     = 8,
   parameter logic [CRC_W-1:0] POLY      = 8'h07,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_out
);
   import crc_status_pkg::*;

   localparam logic [CRC_W-1:0] POLY_R =
      CRC_W'(mirror_bits(CRC_W_MAX'(POLY), CRC_W));

   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = crc_in;

   generate
      if (MSB_FIRST) begin : g_msb
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic fb;
            assign fb = chain[i][CRC_W-1] ^ data[DATA_W-1-i];
            assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
         end
      end else begin : g_lsb
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic fb;
            assign fb = chain[i][0] ^ data[i];
            assign chain[i+1] = {1'b0, chain[i][CRC_W-1:1]} ^ (fb ? POLY_R : '0);
         end
      end
   endgenerate

   assign crc_out = chain[DATA_W];

endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
   parameter int unsigned      DATA_W    = 8,
   parameter int unsigned      CRC_W     = 8,
   parameter logic [CRC_W-1:0] POLY      = 8'h07,
   parameter logic [CRC_W-1:0] SEED      = 8'h00,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              clr_i,
   input  logic              strobe_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  run_o,
   output logic              pend_o
);
   logic [CRC_W-1:0] run_q;
   logic             pend_q;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] folded;

   // A clear restarts from the seed before a same-cycle byte is folded in
   assign base = clr_i ? SEED : run_q;

   crc_step #(
      .DATA_W    (DATA_W),
      .CRC_W     (CRC_W),
      .POLY      (POLY),
      .MSB_FIRST (MSB_FIRST)
   ) u_step (
      .crc_in  (base),
      .data    (data_i),
      .crc_out (folded)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= SEED;
         pend_q <= 1'b0;
      end else if (!en_i) begin
         run_q  <= SEED;
         pend_q <= 1'b0;
      end else begin
         run_q  <= strobe_i ? folded : base;
         pend_q <= strobe_i;
      end
   end

   assign run_o  = run_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/crc_flag_ctrl.sv
module crc_flag_ctrl #(
   parameter int unsigned CRC_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             strobe_i,
   input  logic             rd_i,
   input  logic             pend_i,
   input  logic [CRC_W-1:0] run_i,
   output logic [CRC_W-1:0] data_o,
   output logic             full_o
);
   logic [CRC_W-1:0] data_q;
   logic             full_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else if (!en_i) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (pend_i) data_q <= run_i;
         // Priority: new strobe clears, pending load sets, read clears
         if (strobe_i)    full_q <= 1'b0;
         else if (pend_i) full_q <= 1'b1;
         else if (rd_i)   full_q <= 1'b0;
      end
   end

   assign data_o = data_q;
   assign full_o = full_q;

endmodule

// File: rtl/crc_byte_status.sv
module crc_byte_status #(
   parameter int unsigned      DATA_W    = 8,
   parameter int unsigned      CRC_W     = 8,
   parameter logic [CRC_W-1:0] POLY      = 8'h07,
   parameter logic [CRC_W-1:0] SEED      = 8'h00,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              byte_done_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              crc_clr_i,
   input  logic              rd_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              full_o
);
   import crc_status_pkg::*;

   generate
      if (CRC_W < 2 || CRC_W > CRC_W_MAX) begin : g_bad_crc_w
         $error("crc_byte_status: CRC_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("crc_byte_status: DATA_W must be at least 1");
      end
   endgenerate

   logic [CRC_W-1:0] run_val;
   logic             load_pend;

   crc_accum #(
      .DATA_W    (DATA_W),
      .CRC_W     (CRC_W),
      .POLY      (POLY),
      .SEED      (SEED),
      .MSB_FIRST (MSB_FIRST)
   ) u_accum (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .clr_i    (crc_clr_i),
      .strobe_i (byte_done_i),
      .data_i   (byte_i),
      .run_o    (run_val),
      .pend_o   (load_pend)
   );

   crc_flag_ctrl #(
      .CRC_W (CRC_W)
   ) u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .strobe_i (byte_done_i),
      .rd_i     (rd_i),
      .pend_i   (load_pend),
      .run_i    (run_val),
      .data_o   (crc_o),
      .full_o   (full_o)
   );

endmodule

// File: rtl/crc_byte_status_chk.sv
module crc_byte_status_chk #(
   parameter int unsigned CRC_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             byte_done_i,
   input logic             rd_i,
   input logic             load_pend,
   input logic [CRC_W-1:0] crc_o,
   input logic             full_o
);
   // R4
   strobe_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_done_i |=> !full_o);

   // R3
   read_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && full_o && rd_i && !byte_done_i) |=> !full_o);

   // R7
   load_beats_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && load_pend && !byte_done_i) |=> full_o);

   // R8
   disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!full_o && crc_o == '0));

   // R9
   value_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && $past(full_o)) |-> $stable(crc_o));

endmodule

bind crc_byte_status crc_byte_status_chk #(.CRC_W(CRC_W)) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .en_i        (en_i),
   .byte_done_i (byte_done_i),
   .rd_i        (rd_i),
   .load_pend   (load_pend),
   .crc_o       (crc_o),
   .full_o      (full_o)
);

// File: tb/test_crc_byte_status.sv
`timescale 1ns/100ps
module test_crc_byte_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       bd = 1'b0;
   logic [7:0] dbyte = 8'h00;
   logic       clr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] crc_o;
   logic       full_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   crc_byte_status i_crc_byte_status (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .en_i        (en),
      .byte_done_i (bd),
      .byte_i      (dbyte),
      .crc_clr_i   (clr),
      .rd_i        (rd),
      .crc_o       (crc_o),
      .full_o      (full_o)
   );

   // Software CRC-8: poly 0x07, MSB first
   function automatic int sw_crc(input int c, input int b);
      for (int i = 0; i < 8; i++) begin
         int fb;
         fb = ((c >> 7) ^ (b >> (7 - i))) & 1;
         c = (c << 1) & 8'hFF;
         if (fb != 0) c = c ^ 8'h07;
      end
      return c;
   endfunction

   // Behavioural reference model
   int  m_run = 0, m_reg = 0;
   bit  m_flag = 0, m_pend = 0;

   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_run = 0; m_reg = 0; m_flag = 0; m_pend = 0;
      end else begin
         bit nf;
         int b;
         nf = m_flag;
         if (bd) nf = 0;
         else if (m_pend) nf = 1;
         else if (rd) nf = 0;
         if (m_pend) m_reg = m_run;
         b = clr ? 0 : m_run;
         m_run = bd ? sw_crc(b, int'(dbyte)) : b;
         m_pend = bd;
         m_flag = nf;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int'(crc_o) == m_reg, "R2 model register", int'(crc_o), m_reg);
         check(full_o == m_flag, "R4 model flag", int'(full_o), int'(m_flag));
      end
   end

   // Drive one strobe; returns at the falling edge after the sampling edge
   task automatic pulse(input logic [7:0] b, input bit with_clr);
      @(negedge clk);
      bd = 1'b1; dbyte = b; clr = with_clr;
      @(negedge clk);
      bd = 1'b0; clr = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic send_string(input bit clr_first);
      for (int k = 1; k <= 9; k++) begin
         pulse(8'(8'h30 + k), clr_first && k == 1);
         check(full_o == 1'b0, "R4 flag low after strobe", int'(full_o), 0);
         @(negedge clk);
         check(full_o == 1'b1, "R2 flag set one edge later", int'(full_o), 1);
      end
   endtask

   initial begin
      int exp1;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      check(crc_o == 8'h00, "R5 reset register", int'(crc_o), 0);
      check(full_o == 1'b0, "R5 reset flag", int'(full_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;

      // R1: check string with a clear on the first byte
      send_string(1'b1);
      check(crc_o == 8'hF4, "R1 check value", int'(crc_o), 'hF4);

      // R3: plain read
      held = crc_o;
      do_read();
      check(full_o == 1'b0, "R3 read clears flag", int'(full_o), 0);
      check(crc_o == held, "R3 value kept after read", int'(crc_o), int'(held));

      // R6: clear alone does not touch register or flag; then restart
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      check(crc_o == held, "R6 clear leaves register", int'(crc_o), int'(held));
      check(full_o == 1'b0, "R6 clear leaves flag", int'(full_o), 0);
      send_string(1'b0);
      check(crc_o == 8'hF4, "R6 restart from seed", int'(crc_o), 'hF4);

      // R4: back-to-back strobes keep the flag low
      @(negedge clk); clr = 1'b1;
      for (int k = 1; k <= 9; k++) begin
         bd = 1'b1; dbyte = 8'(8'h30 + k);
         @(negedge clk);
         clr = 1'b0;
         check(full_o == 1'b0, "R4 flag low in burst", int'(full_o), 0);
      end
      bd = 1'b0;
      @(negedge clk);
      check(full_o == 1'b1, "R4 flag rises after burst", int'(full_o), 1);
      check(crc_o == 8'hF4, "R1 burst check value", int'(crc_o), 'hF4);

      // R9: unread value stays put
      repeat (3) @(negedge clk);
      check(crc_o == 8'hF4, "R9 value held while full", int'(crc_o), 'hF4);

      // R7: read on the load edge
      pulse(8'hA5, 1'b1);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      exp1 = sw_crc(0, 'hA5);
      check(full_o == 1'b1, "R7 load wins over read", int'(full_o), 1);
      check(int'(crc_o) == exp1, "R7 loaded value", int'(crc_o), exp1);

      // R8: disable clears and ignores strobes
      @(negedge clk); en = 1'b0;
      @(negedge clk);
      check(crc_o == 8'h00, "R8 disable clears register", int'(crc_o), 0);
      check(full_o == 1'b0, "R8 disable clears flag", int'(full_o), 0);
      pulse(8'h5A, 1'b0);
      @(negedge clk);
      check(full_o == 1'b0, "R8 strobe ignored flag", int'(full_o), 0);
      check(crc_o == 8'h00, "R8 strobe ignored register", int'(crc_o), 0);
      en = 1'b1;
      pulse(8'hFF, 1'b0);
      @(negedge clk);
      exp1 = sw_crc(0, 'hFF);
      check(int'(crc_o) == exp1, "R8 running value was reset", int'(crc_o), exp1);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog R1: actual 0x0 expected 0x1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule